// File: doc/BRIEF.md
# Trap Arbitration and Entry Sequencer

This block decides when a processor leaves its normal instruction flow to enter a trap handler, and then carries out the entry. It watches nine hardware fault lines, a software trap request with an 8-bit vector number, and a pending maskable interrupt with its priority level. A trap is never masked and always beats the interrupt. The block waits for the current instruction to complete before it starts the entry.

On entry, the block saves the status word, the code segment and the instruction pointer through a single stack write port. The code segment is saved only when segmentation is on. After the last write is acknowledged, the block pulses a jump strobe with the handler address. With that strobe it gives the handler's code segment, taken from a dedicated vector segment input, and the status word the handler should run with.

Hardware faults are captured in sticky pending bits. A fault that loses arbitration is served at a later entry. A small handshake answers a return-from-interrupt request while no entry is in progress.

Top module: `trap_entry_seq`

## Requirements
- R1: When any trap is pending or requested, `irq_take_o` stays low whatever `irq_level_i` is. With no trap, `irq_take_o` is high combinationally only when `irq_req_i`, `insn_done_i` and idle all hold and `irq_level_i` is nonzero.
- R2: Hardware inputs have fixed priority, with bit 0 highest and bit 8 lowest. Each entry serves one winner, and it clears only that winner's sticky pending bit. A losing bit stays pending and is served at a later completion strobe.
- R3: A pending hardware trap wins over a simultaneous software trap.
- R4: An entry starts only at a clock edge where `insn_done_i` is high and the block is idle. A fault raised without the strobe is held pending until a strobe arrives.
- R5: The handler address is the vector number times four. A software trap uses `sw_trap_vec_i`. Hardware inputs 0..8 use vector numbers 0x02, 0x03, 0x04, 0x06, 0x07, 0x08, 0x09, 0x0A and 0x0B.
- R6: The saving order is status word, then code segment (zero-extended, only when `seg_mode_i` was high at entry), then instruction pointer. Each word stays on `stk_data_o` with `stk_we_o` high until `stk_ack_i` is seen.
- R7: `csp_new_o` gives the `vecseg_i` value sampled at entry.
- R8: For a software trap, `psw_new_o` equals the saved status word, and `irq_take_o` stays low. For a hardware trap, its priority field, bits [15:12], is forced to 0xF.
- R9: `busy_o` rises in the cycle after arbitration and falls after the last acknowledged write. `jump_o` is a one-cycle pulse in that following cycle.
- R10: `reti_ack_o` pulses one cycle after `reti_req_i` is seen while idle. It stays low while the block is busy.
- R11: After reset the block is idle: no busy, no write, no jump, no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_trap_i | input | 9 | Hardware trap conditions, bit 0 highest priority |
| sw_trap_req_i | input | 1 | Software trap request, held until entry |
| sw_trap_vec_i | input | 8 | Software trap vector number |
| irq_req_i | input | 1 | Pending maskable interrupt |
| irq_level_i | input | 4 | Priority level of that interrupt |
| insn_done_i | input | 1 | Current instruction completes this cycle |
| seg_mode_i | input | 1 | Segmentation mode enabled |
| psw_i | input | 16 | Current status word |
| csp_i | input | 8 | Current code segment |
| ip_i | input | 16 | Return instruction pointer |
| vecseg_i | input | 8 | Vector segment value for handlers |
| irq_take_o | output | 1 | Interrupt may be accepted now |
| busy_o | output | 1 | Entry sequence in progress |
| stk_we_o | output | 1 | Stack write request |
| stk_data_o | output | 16 | Stack write data |
| stk_ack_i | input | 1 | Stack write accepted |
| jump_o | output | 1 | Branch to handler now |
| vec_addr_o | output | 10 | Handler address |
| csp_new_o | output | 8 | Handler code segment |
| psw_new_o | output | 16 | Status word for the handler |
| reti_req_i | input | 1 | Return-from-interrupt request |
| reti_ack_o | output | 1 | Return request accepted |

## Verification
`irq_take_o` is combinational, so the bench checks it 1 ns after driving the completion strobe, in the same cycle. `busy_o` and the first stack word are due one edge after that strobe. Each further word follows one edge after its acknowledge, and `jump_o` comes one edge after the last one. The bench drives inputs on falling edges and samples there. It counts the acknowledged writes cycle by cycle and reads the address, segment and status word on the cycle `jump_o` is high. `reti_ack_o` is checked one edge after its request.

// File: rtl/trap_entry_seq.sv
module trap_entry_seq #(
  parameter int N_HW   = 9,
  parameter int VEC_W  = 8,
  parameter int DATA_W = 16,
  parameter int SEG_W  = 8,
  parameter int LVL_W  = 4,
  parameter logic [N_HW*VEC_W-1:0] HW_VEC =
    {8'h0B, 8'h0A, 8'h09, 8'h08, 8'h07, 8'h06, 8'h04, 8'h03, 8'h02}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_HW-1:0]     hw_trap_i,
  input  logic                sw_trap_req_i,
  input  logic [VEC_W-1:0]    sw_trap_vec_i,
  input  logic                irq_req_i,
  input  logic [LVL_W-1:0]    irq_level_i,
  input  logic                insn_done_i,
  input  logic                seg_mode_i,
  input  logic [DATA_W-1:0]   psw_i,
  input  logic [SEG_W-1:0]    csp_i,
  input  logic [DATA_W-1:0]   ip_i,
  input  logic [SEG_W-1:0]    vecseg_i,
  output logic                irq_take_o,
  output logic                busy_o,
  output logic                stk_we_o,
  output logic [DATA_W-1:0]   stk_data_o,
  input  logic                stk_ack_i,
  output logic                jump_o,
  output logic [VEC_W+1:0]    vec_addr_o,
  output logic [SEG_W-1:0]    csp_new_o,
  output logic [DATA_W-1:0]   psw_new_o,
  input  logic                reti_req_i,
  output logic                reti_ack_o
);

  localparam int IDX_W = (N_HW > 1) ? $clog2(N_HW) : 1;

  typedef enum logic [1:0] {S_IDLE, S_PSW, S_CSP, S_IP} state_t;

  state_t            state;
  logic [N_HW-1:0]   pend_q;
  logic [DATA_W-1:0] psw_q, ip_q;
  logic [SEG_W-1:0]  csp_q, vseg_q;
  logic [VEC_W-1:0]  vec_q;
  logic              seg_q, hw_q, jump_q, reti_q;

  logic [N_HW-1:0]   pend_all, clr_mask;
  logic [IDX_W-1:0]  win_idx;
  logic [VEC_W-1:0]  win_vec, sel_vec;
  logic              hw_any, idle, take;

  assign pend_all = pend_q | hw_trap_i;
  assign hw_any   = |pend_all;
  assign idle     = (state == S_IDLE);
  assign take     = idle && insn_done_i && (hw_any || sw_trap_req_i);

  always_comb begin
    win_idx = '0;
    for (int i = N_HW - 1; i >= 0; i--)
      if (pend_all[i]) win_idx = IDX_W'(i);
  end

  assign win_vec  = HW_VEC[win_idx*VEC_W +: VEC_W];
  assign sel_vec  = hw_any ? win_vec : sw_trap_vec_i;
  assign clr_mask = (take && hw_any) ? (N_HW'(1) << win_idx) : '0;

  assign irq_take_o = idle && insn_done_i && irq_req_i && (irq_level_i != '0)
                      && !hw_any && !sw_trap_req_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      pend_q <= '0;
      psw_q  <= '0;
      ip_q   <= '0;
      csp_q  <= '0;
      vseg_q <= '0;
      vec_q  <= '0;
      seg_q  <= 1'b0;
      hw_q   <= 1'b0;
      jump_q <= 1'b0;
      reti_q <= 1'b0;
    end else begin
      pend_q <= pend_all & ~clr_mask;
      jump_q <= 1'b0;
      reti_q <= reti_req_i && idle;
      case (state)
        S_IDLE: if (take) begin
          psw_q  <= psw_i;
          csp_q  <= csp_i;
          ip_q   <= ip_i;
          seg_q  <= seg_mode_i;
          vseg_q <= vecseg_i;
          vec_q  <= sel_vec;
          hw_q   <= hw_any;
          state  <= S_PSW;
        end
        S_PSW: if (stk_ack_i) state <= seg_q ? S_CSP : S_IP;
        S_CSP: if (stk_ack_i) state <= S_IP;
        S_IP:  if (stk_ack_i) begin
          state  <= S_IDLE;
          jump_q <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = !idle;
  assign stk_we_o   = !idle;
  assign stk_data_o = (state == S_PSW) ? psw_q :
                      (state == S_CSP) ? {{(DATA_W-SEG_W){1'b0}}, csp_q} : ip_q;
  assign jump_o     = jump_q;
  assign vec_addr_o = {vec_q, 2'b00};
  assign csp_new_o  = vseg_q;
  assign psw_new_o  = hw_q ? {{LVL_W{1'b1}}, psw_q[DATA_W-LVL_W-1:0]} : psw_q;
  assign reti_ack_o = reti_q;

  assert_trap_beats_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take_o |-> !take);

  assert_entry_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(insn_done_i));

  assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_we_o && !stk_ack_i) |=> (stk_we_o && $stable(stk_data_o)));

  assert_jump_after_last_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    jump_o |-> (!busy_o && $past(stk_we_o && stk_ack_i)));

  assert_reti_only_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reti_ack_o |-> $past(reti_req_i && !busy_o));

  assert_loser_stays_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && hw_any) |=> ($countones(pend_q) >= $past($countones(pend_all)) - 1));

endmodule

// File: tb/tb_trap_entry_seq.sv
module tb_trap_entry_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [8:0]  hw_trap_i = '0;
  logic        sw_trap_req_i = 1'b0;
  logic [7:0]  sw_trap_vec_i = '0;
  logic        irq_req_i = 1'b0;
  logic [3:0]  irq_level_i = '0;
  logic        insn_done_i = 1'b0;
  logic        seg_mode_i = 1'b0;
  logic [15:0] psw_i = 16'h2345;
  logic [7:0]  csp_i = 8'h5A;
  logic [15:0] ip_i = 16'hBEEF;
  logic [7:0]  vecseg_i = 8'hC3;
  logic        stk_ack_i = 1'b1;
  logic        reti_req_i = 1'b0;
  logic        irq_take_o, busy_o, stk_we_o, jump_o, reti_ack_o;
  logic [15:0] stk_data_o, psw_new_o;
  logic [9:0]  vec_addr_o;
  logic [7:0]  csp_new_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trap_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .hw_trap_i(hw_trap_i), .sw_trap_req_i(sw_trap_req_i),
    .sw_trap_vec_i(sw_trap_vec_i), .irq_req_i(irq_req_i), .irq_level_i(irq_level_i),
    .insn_done_i(insn_done_i), .seg_mode_i(seg_mode_i), .psw_i(psw_i), .csp_i(csp_i),
    .ip_i(ip_i), .vecseg_i(vecseg_i), .irq_take_o(irq_take_o), .busy_o(busy_o),
    .stk_we_o(stk_we_o), .stk_data_o(stk_data_o), .stk_ack_i(stk_ack_i),
    .jump_o(jump_o), .vec_addr_o(vec_addr_o), .csp_new_o(csp_new_o),
    .psw_new_o(psw_new_o), .reti_req_i(reti_req_i), .reti_ack_o(reti_ack_o)
  );

  typedef struct packed {
    logic [8:0] hw;
    logic       sw;
    logic [7:0] swv;
    logic       seg;
    logic [9:0] exp_va;
    logic       exp_hw;
  } row_t;

  localparam int NROWS = 6;
  localparam row_t ROWS [NROWS] = '{
    '{9'h001, 1'b0, 8'h00, 1'b1, 10'h008, 1'b1},
    '{9'h100, 1'b0, 8'h00, 1'b0, 10'h02C, 1'b1},
    '{9'h000, 1'b1, 8'h20, 1'b1, 10'h080, 1'b0},
    '{9'h008, 1'b1, 8'h30, 1'b1, 10'h018, 1'b1},
    '{9'h000, 1'b1, 8'hFF, 1'b0, 10'h3FC, 1'b0},
    '{9'h080, 1'b0, 8'h00, 1'b1, 10'h028, 1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_entry(input logic [8:0] hw, input logic sw, input logic [7:0] swv,
                           input logic seg, input logic [9:0] exp_va, input logic exp_hw,
                           input int stall);
    logic [15:0] got [4];
    int n = 0;
    bit seen = 1'b0;
    @(negedge clk);
    hw_trap_i = hw; sw_trap_req_i = sw; sw_trap_vec_i = swv; seg_mode_i = seg;
    insn_done_i = 1'b1; irq_req_i = 1'b1; irq_level_i = 4'hF;
    if (stall > 0) stk_ack_i = 1'b0;
    #1 check(irq_take_o == 1'b0, "R1/R8 irq_take under trap", irq_take_o, 0);
    @(negedge clk);
    hw_trap_i = '0; sw_trap_req_i = 1'b0; insn_done_i = 1'b0; irq_req_i = 1'b0;
    check(busy_o == 1'b1, "R9 busy after arbitration", busy_o, 1);
    for (int s = 0; s < stall; s++) begin
      reti_req_i = 1'b1;
      check(stk_we_o && stk_data_o == psw_i, "R6 held until ack", stk_data_o, psw_i);
      @(negedge clk);
      check(reti_ack_o == 1'b0, "R10 no reti ack while busy", reti_ack_o, 0);
    end
    reti_req_i = 1'b0;
    stk_ack_i = 1'b1;
    for (int k = 0; k < 40; k++) begin
      if (jump_o) begin seen = 1'b1; break; end
      if (stk_we_o && stk_ack_i && n < 4) begin got[n] = stk_data_o; n++; end
      @(negedge clk);
    end
    check(seen, "R9 jump pulse", seen, 1);
    check(busy_o == 1'b0, "R9 busy low at jump", busy_o, 0);
    check(n == (seg ? 3 : 2), "R6 push count", n, seg ? 3 : 2);
    check(got[0] == psw_i, "R6 first push status", got[0], psw_i);
    if (seg) begin
      check(got[1] == {8'h00, csp_i}, "R6 second push segment", got[1], {8'h00, csp_i});
      check(got[2] == ip_i, "R6 third push pointer", got[2], ip_i);
    end else begin
      check(got[1] == ip_i, "R6 second push pointer", got[1], ip_i);
    end
    check(vec_addr_o == exp_va, "R5/R2/R3 vector address", vec_addr_o, exp_va);
    check(csp_new_o == vecseg_i, "R7 handler segment", csp_new_o, vecseg_i);
    check(psw_new_o == (exp_hw ? {4'hF, psw_i[11:0]} : psw_i), "R8 handler status",
          psw_new_o, exp_hw ? {4'hF, psw_i[11:0]} : psw_i);
    @(negedge clk);
    check(jump_o == 1'b0, "R9 jump one cycle", jump_o, 0);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!busy_o && !stk_we_o && !jump_o && !reti_ack_o && !irq_take_o,
          "R11 reset idle", {busy_o, stk_we_o, jump_o, reti_ack_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !stk_we_o, "R11 idle after release", busy_o, 0);

    for (int r = 0; r < NROWS; r++)
      run_entry(ROWS[r].hw, ROWS[r].sw, ROWS[r].swv, ROWS[r].seg,
                ROWS[r].exp_va, ROWS[r].exp_hw, 0);

    // R2: bits 2 and 5 together; bit 2 first, bit 5 remains pending
    run_entry(9'h024, 1'b0, 8'h00, 1'b1, 10'h010, 1'b1, 0);
    run_entry(9'h000, 1'b0, 8'h00, 1'b0, 10'h020, 1'b1, 0);

    // R4: fault without completion strobe waits
    @(negedge clk);
    hw_trap_i = 9'h001;
    @(negedge clk);
    hw_trap_i = '0;
    repeat (3) @(negedge clk);
    check(!busy_o && !stk_we_o, "R4 no entry without strobe", busy_o, 0);
    run_entry(9'h000, 1'b0, 8'h00, 1'b1, 10'h008, 1'b1, 0);

    // R6/R10: stalled acknowledge with a return request during busy
    run_entry(9'h002, 1'b0, 8'h00, 1'b1, 10'h00C, 1'b1, 3);

    // R1: interrupt alone
    @(negedge clk);
    irq_req_i = 1'b1; irq_level_i = 4'h3; insn_done_i = 1'b1;
    #1 check(irq_take_o == 1'b1, "R1 irq taken with no trap", irq_take_o, 1);
    irq_level_i = 4'h0;
    #1 check(irq_take_o == 1'b0, "R1 level zero not taken", irq_take_o, 0);
    irq_level_i = 4'h3; insn_done_i = 1'b0;
    #1 check(irq_take_o == 1'b0, "R1 waits for completion", irq_take_o, 0);
    irq_req_i = 1'b0;

    // R10: return request while idle
    @(negedge clk);
    reti_req_i = 1'b1;
    @(negedge clk);
    reti_req_i = 1'b0;
    check(reti_ack_o == 1'b1, "R10 reti ack when idle", reti_ack_o, 1);
    @(negedge clk);
    check(reti_ack_o == 1'b0, "R10 reti ack one cycle", reti_ack_o, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule